// File: doc/BRIEF.md
# Prioritised Exception Entry and Return Unit

This unit sits beside an in-order processor pipeline. Each cycle it looks at exception requests from the pipeline, the timers, the debug logic and six external interrupt pins. When at least one request is eligible, it takes exactly one of them, chosen by a fixed priority. It classifies the winner as critical or noncritical. It saves a return address and the current machine state into the save/restore pair that belongs to that class. It also updates the machine state and redirects the fetch address to a per-type vector.

The two classes keep separate save pairs. A noncritical handler can therefore be interrupted by a critical one without losing its own context. Each pair has its own return request, which restores the program counter and the machine state from that pair.

External pins are level-sensitive. Each passes through a two-flop synchroniser into a sticky status bit, which software clears by writing 1. Each pin has its own enable. The first cycle after reset produces a reset-class redirect.

Top module: `exc_unit`

## Requirements
- R1: While `rst` is high, `msr`, all four save registers and `pin_status` are zero, and `redirect_valid` is low. On the first clock edge with `rst` low, the unit redirects to `VEC_BASE` with class 1 (reset) and code 0, and sets `msr` to zero.
- R2: When several requests are eligible in the same cycle, only the one with the lowest code is taken. The codes are: machine check 1, debug 2, critical pin 3, watchdog 4, program 5, data storage 6, TLB miss 7, system call 8, alignment 9, external pins 10, fixed interval timer 11, programmable interval timer 12.
- R3: Codes 1 to 4 are critical (class 2). They write the save address to `srr2` and the previous `msr` to `srr3`, and leave `srr0` and `srr1` unchanged.
- R4: Codes 5 to 12 are noncritical (class 3). They write the save address to `srr0` and the previous `msr` to `srr1`, and leave `srr2` and `srr3` unchanged.
- R5: The save address is `cur_pc` for program, data storage, TLB miss and alignment, and `next_pc` for every other exception. When `mc_busy` is high, the save address is `cur_pc` regardless of the exception type, because the running multicycle instruction is aborted.
- R6: On entry, the new `msr` equals the old `msr` with bit `EE_BIT` cleared; for a critical exception, bit `CE_BIT` is also cleared. The new value is visible in the same cycle as the redirect.
- R7: The watchdog and the critical pin are taken only while `msr[CE_BIT]` is 1. The external pins, the fixed interval timer and the programmable interval timer are taken only while `msr[EE_BIT]` is 1. Machine check and the synchronous requests are never gated.
- R8: A return from noncritical (`rfi`) redirects to `srr0` and loads `msr` from `srr1`. A return from critical (`rfci`) redirects to `srr2` and loads `msr` from `srr3`. Both produce class 0. `rfci` wins over `rfi`, and a taken exception wins over both.
- R9: An exception redirect goes to `VEC_BASE + code * VEC_STRIDE`. All redirects appear as a one-cycle pulse on `redirect_valid`, one edge after the request is sampled.
- R10: Pin bit 0 is the critical pin; bits 1 to 5 are general pins. A pin that goes high is reflected in `pin_status` on the 3rd edge and taken on the 4th edge. A status bit stays set until it is cleared by writing 1 through `stat_clr_we`/`stat_clr`. If the pin is still high in the same cycle as the clear, the bit stays set.
- R11: A pin whose `pin_en` bit is 0 still sets its status bit but raises no exception. Once the enable bit goes to 1, the pending status is taken at the next edge.
- R12: When no exception, reset redirect or return occurs in a cycle, `msr_we` loads `msr_wdata` into `msr` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 10 | Requests: bit0 machine check, 1 debug, 2 watchdog, 3 program, 4 data storage, 5 TLB miss, 6 system call, 7 alignment, 8 fixed interval timer, 9 programmable interval timer |
| pin_lvl | input | NPIN | Asynchronous external pin levels, bit 0 critical |
| pin_en | input | NPIN | Per-pin enable |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr | input | NPIN | Write-1-to-clear mask for pin status |
| cur_pc | input | AW | Address of the instruction in execution |
| next_pc | input | AW | Next sequential address |
| mc_busy | input | 1 | A multicycle instruction is in progress |
| rfi | input | 1 | Return from noncritical handler |
| rfci | input | 1 | Return from critical handler |
| msr_we | input | 1 | Machine state write strobe |
| msr_wdata | input | MW | Machine state write value |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | AW | Redirect target |
| exc_class | output | 2 | 0 return, 1 reset, 2 critical, 3 noncritical |
| exc_code | output | 4 | Code of the taken exception |
| msr | output | MW | Current machine state |
| srr0 | output | AW | Noncritical save address |
| srr1 | output | MW | Noncritical saved state |
| srr2 | output | AW | Critical save address |
| srr3 | output | MW | Critical saved state |
| pin_status | output | NPIN | Sticky pin status |

## Verification
A wrong priority, class or gating decision shows on the very edge that takes the exception. That edge exposes the wrong `exc_code`, the wrong vector on `redirect_pc`, or a write into the wrong save pair. A corrupted `msr` or save register stays silent until the next entry or return. At that point it surfaces as a wrong saved state or a wrong restore target, or as an eligible interrupt that never fires. Synchroniser faults appear as a latency other than four edges from pin to redirect.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCORE = 10;
  localparam int NSRC  = 12;
  localparam int CW    = 4;

  // core_req bit positions
  localparam int CB_MCHK  = 0;
  localparam int CB_DEBUG = 1;
  localparam int CB_WDOG  = 2;
  localparam int CB_PROG  = 3;
  localparam int CB_DSTOR = 4;
  localparam int CB_TLB   = 5;
  localparam int CB_SC    = 6;
  localparam int CB_ALIGN = 7;
  localparam int CB_FIT   = 8;
  localparam int CB_PIT   = 9;

  // priority slots, lowest index wins; code = slot + 1
  localparam int SL_LAST_CRIT = 3;
  localparam int SL_PROG  = 4;
  localparam int SL_DSTOR = 5;
  localparam int SL_TLB   = 6;
  localparam int SL_ALIGN = 8;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_RESET   = 2'd1,
    CLS_CRIT    = 2'd2,
    CLS_NONCRIT = 2'd3
  } exc_class_e;
endpackage

// File: rtl/exc_pin_sync.sv
module exc_pin_sync #(
  parameter int NPIN = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] lvl,
  input  logic            clr_we,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] status
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic meta, sync, stick;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta  <= 1'b0;
        sync  <= 1'b0;
        stick <= 1'b0;
      end else begin
        meta  <= lvl[g];
        sync  <= meta;
        // a live level outranks a clear in the same cycle
        stick <= sync | (stick & ~(clr_we & clr[g]));
      end
    end
    assign status[g] = stick;
  end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
#(
  parameter int NPIN = 6
) (
  input  logic [NCORE-1:0] core_req,
  input  logic [NPIN-1:0]  status,
  input  logic [NPIN-1:0]  pin_en,
  input  logic             ee,
  input  logic             ce,
  output logic             hit,
  output logic [CW-1:0]    code,
  output logic             crit,
  output logic             use_cur
);
  logic [NPIN-1:0] live;
  logic [NSRC-1:0] src;
  logic [CW-1:0]   slot;

  assign live = status & pin_en;

  always_comb begin
    src     = '0;
    src[0]  = core_req[CB_MCHK];
    src[1]  = core_req[CB_DEBUG];
    src[2]  = live[0] & ce;
    src[3]  = core_req[CB_WDOG] & ce;
    src[4]  = core_req[CB_PROG];
    src[5]  = core_req[CB_DSTOR];
    src[6]  = core_req[CB_TLB];
    src[7]  = core_req[CB_SC];
    src[8]  = core_req[CB_ALIGN];
    src[9]  = (|live[NPIN-1:1]) & ee;
    src[10] = core_req[CB_FIT] & ee;
    src[11] = core_req[CB_PIT] & ee;
  end

  always_comb begin
    hit  = 1'b0;
    slot = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src[i]) begin
        hit  = 1'b1;
        slot = CW'(i);
      end
    end
  end

  assign code    = slot + CW'(1);
  assign crit    = (slot <= CW'(SL_LAST_CRIT));
  assign use_cur = (slot == CW'(SL_PROG))  || (slot == CW'(SL_DSTOR)) ||
                   (slot == CW'(SL_TLB))   || (slot == CW'(SL_ALIGN));
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            MW         = 16,
  parameter int            EE_BIT     = 4,
  parameter int            CE_BIT     = 5,
  parameter logic [AW-1:0] VEC_BASE   = 'h100,
  parameter logic [AW-1:0] VEC_STRIDE = 'h20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [CW-1:0] code,
  input  logic          crit,
  input  logic          use_cur,
  input  logic          mc_busy,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] next_pc,
  input  logic          rfi,
  input  logic          rfci,
  input  logic          msr_we,
  input  logic [MW-1:0] msr_wdata,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output exc_class_e    exc_class,
  output logic [CW-1:0] exc_code,
  output logic [MW-1:0] msr,
  output logic [AW-1:0] srr0,
  output logic [MW-1:0] srr1,
  output logic [AW-1:0] srr2,
  output logic [MW-1:0] srr3
);
  logic          rst_pend;
  logic [MW-1:0] msr_entry;
  logic [AW-1:0] save_pc;
  logic [AW-1:0] vec_pc;

  always_comb begin
    msr_entry         = msr;
    msr_entry[EE_BIT] = 1'b0;
    if (crit) msr_entry[CE_BIT] = 1'b0;
  end

  assign save_pc = (use_cur || mc_busy) ? cur_pc : next_pc;
  assign vec_pc  = VEC_BASE + AW'(code) * VEC_STRIDE;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend       <= 1'b1;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      exc_class      <= CLS_NONE;
      exc_code       <= '0;
      msr            <= '0;
      srr0           <= '0;
      srr1           <= '0;
      srr2           <= '0;
      srr3           <= '0;
    end else begin
      redirect_valid <= 1'b0;
      exc_class      <= CLS_NONE;
      exc_code       <= '0;
      if (rst_pend) begin
        rst_pend       <= 1'b0;
        redirect_valid <= 1'b1;
        redirect_pc    <= VEC_BASE;
        exc_class      <= CLS_RESET;
        msr            <= '0;
      end else if (hit) begin
        redirect_valid <= 1'b1;
        redirect_pc    <= vec_pc;
        exc_class      <= crit ? CLS_CRIT : CLS_NONCRIT;
        exc_code       <= code;
        msr            <= msr_entry;
        if (crit) begin
          srr2 <= save_pc;
          srr3 <= msr;
        end else begin
          srr0 <= save_pc;
          srr1 <= msr;
        end
      end else if (rfci) begin
        redirect_valid <= 1'b1;
        redirect_pc    <= srr2;
        msr            <= srr3;
      end else if (rfi) begin
        redirect_valid <= 1'b1;
        redirect_pc    <= srr0;
        msr            <= srr1;
      end else if (msr_we) begin
        msr <= msr_wdata;
      end
    end
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            MW         = 16,
  parameter int            EE_BIT     = 4,
  parameter int            CE_BIT     = 5,
  parameter int            NPIN       = 6,
  parameter logic [AW-1:0] VEC_BASE   = 'h100,
  parameter logic [AW-1:0] VEC_STRIDE = 'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCORE-1:0] core_req,
  input  logic [NPIN-1:0]  pin_lvl,
  input  logic [NPIN-1:0]  pin_en,
  input  logic             stat_clr_we,
  input  logic [NPIN-1:0]  stat_clr,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    next_pc,
  input  logic             mc_busy,
  input  logic             rfi,
  input  logic             rfci,
  input  logic             msr_we,
  input  logic [MW-1:0]    msr_wdata,
  output logic             redirect_valid,
  output logic [AW-1:0]    redirect_pc,
  output logic [1:0]       exc_class,
  output logic [CW-1:0]    exc_code,
  output logic [MW-1:0]    msr,
  output logic [AW-1:0]    srr0,
  output logic [MW-1:0]    srr1,
  output logic [AW-1:0]    srr2,
  output logic [MW-1:0]    srr3,
  output logic [NPIN-1:0]  pin_status
);
  logic          hit, crit, use_cur;
  logic [CW-1:0] code;
  exc_class_e    cls;

  exc_pin_sync #(.NPIN(NPIN)) u_pins (
    .clk    (clk),
    .rst    (rst),
    .lvl    (pin_lvl),
    .clr_we (stat_clr_we),
    .clr    (stat_clr),
    .status (pin_status)
  );

  exc_prio #(.NPIN(NPIN)) u_prio (
    .core_req (core_req),
    .status   (pin_status),
    .pin_en   (pin_en),
    .ee       (msr[EE_BIT]),
    .ce       (msr[CE_BIT]),
    .hit      (hit),
    .code     (code),
    .crit     (crit),
    .use_cur  (use_cur)
  );

  exc_state #(
    .AW(AW), .MW(MW), .EE_BIT(EE_BIT), .CE_BIT(CE_BIT),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_state (
    .clk            (clk),
    .rst            (rst),
    .hit            (hit),
    .code           (code),
    .crit           (crit),
    .use_cur        (use_cur),
    .mc_busy        (mc_busy),
    .cur_pc         (cur_pc),
    .next_pc        (next_pc),
    .rfi            (rfi),
    .rfci           (rfci),
    .msr_we         (msr_we),
    .msr_wdata      (msr_wdata),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .exc_class      (cls),
    .exc_code       (exc_code),
    .msr            (msr),
    .srr0           (srr0),
    .srr1           (srr1),
    .srr2           (srr2),
    .srr3           (srr3)
  );

  assign exc_class = cls;
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
  parameter int AW     = 32,
  parameter int MW     = 16,
  parameter int EE_BIT = 4,
  parameter int CE_BIT = 5,
  parameter int NPIN   = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            rfci,
  input logic            stat_clr_we,
  input logic            redirect_valid,
  input logic [AW-1:0]   redirect_pc,
  input logic [1:0]      exc_class,
  input logic [3:0]      exc_code,
  input logic [MW-1:0]   msr,
  input logic [AW-1:0]   srr0,
  input logic [MW-1:0]   srr1,
  input logic [AW-1:0]   srr2,
  input logic [MW-1:0]   srr3,
  input logic [NPIN-1:0] pin_status
);
  // R1: reset release produces a reset-class redirect
  a_r1_reset_redirect: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (redirect_valid && exc_class == 2'd1));

  // R3, R6: critical entry uses pair 2/3 and clears both enables
  a_r3_crit_pair: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && exc_class == 2'd2) |->
      ($stable(srr0) && $stable(srr1) && srr3 == $past(msr) &&
       !msr[CE_BIT] && !msr[EE_BIT]));

  // R4, R6: noncritical entry uses pair 0/1 and clears EE
  a_r4_noncrit_pair: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && exc_class == 2'd3) |->
      ($stable(srr2) && $stable(srr3) && srr1 == $past(msr) && !msr[EE_BIT]));

  // R7: enable-gated noncritical sources need EE set beforehand
  a_r7_ee_gate: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && exc_class == 2'd3 && exc_code >= 4'd10) |-> $past(msr[EE_BIT]));

  // R8: returns restore from the pair selected by the return kind
  a_r8_return_target: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && exc_class == 2'd0) |->
      ($past(rfci) ? (redirect_pc == $past(srr2) && msr == $past(srr3))
                   : (redirect_pc == $past(srr0) && msr == $past(srr1))));

  // R10: status bits never drop without a clear strobe
  a_r10_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(stat_clr_we) |-> ((pin_status & $past(pin_status)) == $past(pin_status)));
endmodule

bind exc_unit exc_unit_chk #(
  .AW(AW), .MW(MW), .EE_BIT(EE_BIT), .CE_BIT(CE_BIT), .NPIN(NPIN)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rfci           (rfci),
  .stat_clr_we    (stat_clr_we),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .exc_class      (exc_class),
  .exc_code       (exc_code),
  .msr            (msr),
  .srr0           (srr0),
  .srr1           (srr1),
  .srr2           (srr2),
  .srr3           (srr3),
  .pin_status     (pin_status)
);

// File: tb/exc_unit_test.sv
module exc_unit_test;
  localparam int AW = 32;
  localparam int MW = 16;
  localparam int EE = 4;
  localparam int CE = 5;
  localparam int NP = 6;
  localparam logic [31:0] VB = 32'h100;
  localparam logic [31:0] VS = 32'h20;
  localparam logic [15:0] MBASE = 16'hA300;

  logic clk = 1'b0;
  logic rst;
  logic [9:0] core_req;
  logic [NP-1:0] pin_lvl, pin_en, stat_clr;
  logic stat_clr_we;
  logic [AW-1:0] cur_pc, next_pc;
  logic mc_busy, rfi, rfci, msr_we;
  logic [MW-1:0] msr_wdata;
  logic redirect_valid;
  logic [AW-1:0] redirect_pc;
  logic [1:0] exc_class;
  logic [3:0] exc_code;
  logic [MW-1:0] msr, srr1, srr3;
  logic [AW-1:0] srr0, srr2;
  logic [NP-1:0] pin_status;

  exc_unit uut (
    .clk(clk), .rst(rst), .core_req(core_req), .pin_lvl(pin_lvl), .pin_en(pin_en),
    .stat_clr_we(stat_clr_we), .stat_clr(stat_clr), .cur_pc(cur_pc), .next_pc(next_pc),
    .mc_busy(mc_busy), .rfi(rfi), .rfci(rfci), .msr_we(msr_we), .msr_wdata(msr_wdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .exc_class(exc_class),
    .exc_code(exc_code), .msr(msr), .srr0(srr0), .srr1(srr1), .srr2(srr2), .srr3(srr3),
    .pin_status(pin_status)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_msr(input logic [15:0] v);
    msr_we = 1'b1; msr_wdata = v;
    step();
    msr_we = 1'b0;
  endtask

  // {req[9:0], mc, ee, ce, valid, code[3:0], crit, cur}
  localparam logic [19:0] TV [18] = '{
    {10'h001, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1,  1'b1, 1'b0},
    {10'h002, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2,  1'b1, 1'b0},
    {10'h004, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4,  1'b1, 1'b0},
    {10'h004, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0},
    {10'h008, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  1'b0, 1'b1},
    {10'h010, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6,  1'b0, 1'b1},
    {10'h020, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7,  1'b0, 1'b1},
    {10'h040, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8,  1'b0, 1'b0},
    {10'h080, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9,  1'b0, 1'b1},
    {10'h100, 1'b0, 1'b1, 1'b0, 1'b1, 4'd11, 1'b0, 1'b0},
    {10'h200, 1'b1, 1'b1, 1'b0, 1'b1, 4'd12, 1'b0, 1'b1},
    {10'h100, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0},
    {10'h288, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5,  1'b0, 1'b1},
    {10'h007, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1,  1'b1, 1'b0},
    {10'h00A, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2,  1'b1, 1'b0},
    {10'h300, 1'b0, 1'b1, 1'b0, 1'b1, 4'd11, 1'b0, 1'b0},
    {10'h00C, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4,  1'b1, 1'b0},
    {10'h070, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6,  1'b0, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] m0, exp_m;
    logic [31:0] p0, p2, exp_save;
    logic [15:0] q1, q3;
    int seen;
    rst = 1'b1; core_req = '0; pin_lvl = '0; pin_en = '1; stat_clr = '0;
    stat_clr_we = 1'b0; cur_pc = '0; next_pc = '0; mc_busy = 1'b0;
    rfi = 1'b0; rfci = 1'b0; msr_we = 1'b0; msr_wdata = '0;
    repeat (3) step();
    // R1 reset state
    chk("R1 msr in reset", 32'(msr), 0);
    chk("R1 srr0 in reset", srr0, 0);
    chk("R1 srr3 in reset", 32'(srr3), 0);
    chk("R1 status in reset", 32'(pin_status), 0);
    chk("R1 no redirect in reset", 32'(redirect_valid), 0);
    rst = 1'b0;
    step();
    chk("R1 reset redirect", 32'(redirect_valid), 1);
    chk("R1 reset class", 32'(exc_class), 1);
    chk("R1 reset vector", redirect_pc, VB);
    step();
    chk("R1 pulse ends", 32'(redirect_valid), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 18; i++) begin
      logic [19:0] v;
      v = TV[i];
      m0 = MBASE | (16'(v[8]) << EE) | (16'(v[7]) << CE);
      set_msr(m0);
      chk("R12 msr write", 32'(msr), 32'(m0));
      p0 = srr0; p2 = srr2; q1 = srr1; q3 = srr3;
      cur_pc = 32'h1000 + 32'(i) * 32'h10;
      next_pc = cur_pc + 32'd4;
      core_req = v[19:10]; mc_busy = v[9];
      step();
      core_req = '0; mc_busy = 1'b0;
      if (v[6]) begin
        exp_save = v[0] ? cur_pc : next_pc;
        exp_m = m0;
        exp_m[EE] = 1'b0;
        if (v[1]) exp_m[CE] = 1'b0;
        chk("R2 taken", 32'(redirect_valid), 1);
        chk("R2 priority code", 32'(exc_code), 32'(v[5:2]));
        chk("R9 vector", redirect_pc, VB + 32'(v[5:2]) * VS);
        chk("R6 new msr", 32'(msr), 32'(exp_m));
        if (v[1]) begin
          chk("R3 class crit", 32'(exc_class), 2);
          chk("R5 srr2 save address", srr2, exp_save);
          chk("R3 srr3 saved msr", 32'(srr3), 32'(m0));
          chk("R3 srr0 untouched", srr0, p0);
          chk("R3 srr1 untouched", 32'(srr1), 32'(q1));
        end else begin
          chk("R4 class noncrit", 32'(exc_class), 3);
          chk("R5 srr0 save address", srr0, exp_save);
          chk("R4 srr1 saved msr", 32'(srr1), 32'(m0));
          chk("R4 srr2 untouched", srr2, p2);
          chk("R4 srr3 untouched", 32'(srr3), 32'(q3));
        end
      end else begin
        chk("R7 gated no redirect", 32'(redirect_valid), 0);
        chk("R7 gated msr kept", 32'(msr), 32'(m0));
        chk("R7 gated srr0 kept", srr0, p0);
        chk("R7 gated srr2 kept", srr2, p2);
      end
      step();
    end

    // R8 returns
    set_msr(16'hA330);
    cur_pc = 32'h2000; next_pc = 32'h2004; core_req = 10'h008;
    step();
    core_req = '0;
    cur_pc = 32'h3000; next_pc = 32'h3004; core_req = 10'h001;
    step();
    core_req = '0;
    chk("R3 nested critical msr", 32'(msr), 32'h0000A300);
    rfci = 1'b1; step(); rfci = 1'b0;
    chk("R8 rfci target", redirect_pc, 32'h3004);
    chk("R8 rfci msr", 32'(msr), 32'h0000A320);
    chk("R8 rfci class", 32'(exc_class), 0);
    rfi = 1'b1; step(); rfi = 1'b0;
    chk("R8 rfi target", redirect_pc, 32'h2000);
    chk("R8 rfi msr", 32'(msr), 32'h0000A330);
    rfi = 1'b1; rfci = 1'b1; step(); rfi = 1'b0; rfci = 1'b0;
    chk("R8 rfci over rfi", redirect_pc, 32'h3004);
    rfi = 1'b1; core_req = 10'h002; cur_pc = 32'h4000; next_pc = 32'h4004;
    step(); rfi = 1'b0; core_req = '0;
    chk("R8 exception over return", 32'(exc_code), 2);
    chk("R8 exception over return class", 32'(exc_class), 2);

    // R10 pin latency and status
    set_msr(16'hA330);
    next_pc = 32'h5004; cur_pc = 32'h5000;
    pin_lvl[1] = 1'b1;
    repeat (2) step();
    chk("R10 status not yet", 32'(pin_status), 0);
    step();
    chk("R10 status on 3rd edge", 32'(pin_status), 32'h2);
    chk("R10 no take on 3rd edge", 32'(redirect_valid), 0);
    step();
    chk("R10 take on 4th edge", 32'(redirect_valid), 1);
    chk("R10 ext code", 32'(exc_code), 10);
    chk("R10 ext saves next", srr0, 32'h5004);
    chk("R10 clear-while-high pending", 32'(pin_status), 32'h2);
    stat_clr_we = 1'b1; stat_clr = 6'h02; step(); stat_clr_we = 1'b0; stat_clr = '0;
    chk("R10 set wins over clear", 32'(pin_status), 32'h2);
    pin_lvl[1] = 1'b0;
    repeat (3) step();
    chk("R10 sticky after pin low", 32'(pin_status), 32'h2);
    stat_clr_we = 1'b1; stat_clr = 6'h02; step(); stat_clr_we = 1'b0; stat_clr = '0;
    chk("R10 write-1 clear", 32'(pin_status), 0);

    // R11 masked critical pin
    set_msr(16'hA330);
    pin_en = 6'h3E; pin_lvl[0] = 1'b1; cur_pc = 32'h6000; next_pc = 32'h6004;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      step();
      if (redirect_valid) seen++;
    end
    chk("R11 masked pin no redirect", 32'(seen), 0);
    chk("R11 masked pin status set", 32'(pin_status), 32'h1);
    chk("R11 msr untouched", 32'(msr), 32'h0000A330);
    pin_en = 6'h3F;
    step();
    chk("R11 unmask takes", 32'(redirect_valid), 1);
    chk("R11 critical pin code", 32'(exc_code), 3);
    chk("R11 critical pin class", 32'(exc_class), 2);
    chk("R11 critical pin save", srr2, 32'h6004);
    pin_lvl[0] = 1'b0;
    repeat (4) step();
    chk("R7 CE cleared blocks retake", 32'(redirect_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule